// File: doc/BRIEF.md
# Device Interrupt Pin Mapper

This block translates a device slot number and one of its four interrupt pins (INTA to INTD) into one of eight shared interrupt request lines, numbered 0 to 7 (lines A to H). Slots 25 to 31 are steered by software through per-slot route words. These words live in a small byte-addressable register space. Every other slot follows a fixed rotation that stays on the upper four lines. Slot 30 is special: its route word cannot be written and reads as zero, and its pins are always tied to lines 4 to 7.

Software reaches the register space through a 32-bit little-endian access port. Every request is taken in the cycle it is presented. The port has no back-pressure, and read data comes back one cycle later with a valid strobe. The lookup port is purely combinational, so interrupt routing logic can query it at any time. A write shows up on the lookup port from the cycle after the write edge.

Top module: `intx_route_map`

## Requirements
- R1: After reset, the route words of slots 25 to 29 and 31 read 16'h3210, and every other byte of the 32-byte space, including slot 30's word, reads zero.
- R2: Slot s in 25..31 owns the little-endian 16-bit word at byte offset 2*(s-25). Pin p (0=INTA .. 3=INTD) uses bits [4p+3:4p] of that word, and the lookup returns the low 3 bits of that field as the line index.
- R3: Slot 30's word (bytes 10 and 11) ignores writes and always reads zero. Lookups of slot 30 pin p return 4+p.
- R4: For slots 0 to 24 the lookup returns ((slot + pin) mod 4) + 4.
- R5: The access address is reduced to its low 5 bits (modulo the 32-byte space) before use.
- R6: An access that would run past byte 31 is shortened to end at byte 31. Bytes beyond that point are not written, no wrap to byte 0 happens, and the matching read lanes return zero.
- R7: acc_size selects the length: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. Data byte lane i (bits [8i+7:8i]) corresponds to address base+i.
- R8: A read request produces rd_valid with its data exactly one cycle later, and rd_valid is low otherwise. A write changes the lookup result from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request, always accepted |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte address, masked to the register space |
| acc_size | input | 2 | Length code: 0=1, 1=2, 2/3=4 bytes |
| acc_wdata | input | 32 | Little-endian write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data, zero in lanes past the clamped length |
| lk_slot | input | 5 | Device slot number to look up |
| lk_pin | input | 2 | Device pin, 0=INTA .. 3=INTD |
| lk_line | output | 3 | Shared request line index, 0=A .. 7=H |

## Verification
Several properties hold every cycle, independent of the register contents, and the checker watches these continuously. Slot 30 always maps to 4+pin. Slots below 25 always land in lines 4 to 7. Read strobes follow read requests by exactly one cycle. A read at the last byte returns zero in its upper lanes. Other behaviour depends on what was written and where, and only the bench's scenarios against a byte model can show it. This covers the reset word values, field extraction including the dropped top bit, address wrapping, clamped writes that leave byte 0 untouched, and the ignored writes to slot 30.

// File: rtl/intx_route_pkg.sv
package intx_route_pkg;
  localparam int FIRST_SLOT = 25;
  localparam int NUM_ROUTED = 7;
  localparam int FIXED_SLOT = 30;
  localparam int PINS       = 4;
  localparam int FIELD_W    = 4;
  localparam int LINE_W     = 3;
  localparam int SLOT_W     = 5;
  localparam int PIN_W      = $clog2(PINS);
  localparam logic [15:0] ROUTE_RESET = 16'h3210;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [NUM_ROUTED-1:0][15:0] route_words_t;

  // Rotation for slots with no route word; always in the upper half.
  function automatic line_t rotate_default(logic [SLOT_W-1:0] slot, logic [PIN_W-1:0] pin);
    logic [1:0] sum;
    sum = slot[1:0] + pin;
    return {1'b1, sum};
  endfunction
endpackage

// File: rtl/intx_route_regs.sv
module intx_route_regs
  import intx_route_pkg::*;
#(
  parameter int SPACE_BYTES = 32,
  parameter int ADDR_IN_W   = 8,
  parameter int DATA_BYTES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic                    acc_write,
  input  logic [ADDR_IN_W-1:0]    acc_addr,
  input  logic [1:0]              acc_size,
  input  logic [8*DATA_BYTES-1:0] acc_wdata,
  output logic                    rd_valid,
  output logic [8*DATA_BYTES-1:0] rd_data,
  output route_words_t            route_words
);
  localparam int AW = $clog2(SPACE_BYTES);
  localparam int LW = AW + 1;
  localparam int RO_LO = 2 * (FIXED_SLOT - FIRST_SLOT);

  function automatic bit is_ro(int b);
    return (b == RO_LO) || (b == RO_LO + 1);
  endfunction

  function automatic logic [7:0] init_byte(int b);
    if (b < 2 * NUM_ROUTED && !is_ro(b))
      return (b % 2 == 0) ? ROUTE_RESET[7:0] : ROUTE_RESET[15:8];
    return 8'h00;
  endfunction

  logic [7:0]    mem [SPACE_BYTES];
  logic [AW-1:0] base;
  logic [LW-1:0] req_len, room, eff_len;
  logic [SPACE_BYTES-1:0] hit;
  logic [SPACE_BYTES-1:0][7:0] wbyte;
  logic [8*DATA_BYTES-1:0] rd_next;

  assign base = AW'(acc_addr);

  always_comb begin
    case (acc_size)
      2'd0:    req_len = LW'(1);
      2'd1:    req_len = LW'(2);
      default: req_len = LW'(4);
    endcase
    room    = LW'(SPACE_BYTES) - {1'b0, base};
    eff_len = (req_len > room) ? room : req_len;
  end

  for (genvar b = 0; b < SPACE_BYTES; b++) begin : g_byte
    logic [LW-1:0] off;
    assign off      = LW'(b) - {1'b0, base};
    assign hit[b]   = (LW'(b) >= {1'b0, base}) && (off < eff_len);
    assign wbyte[b] = acc_wdata[8*off[1:0] +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < SPACE_BYTES; b++) mem[b] <= init_byte(b);
    end else if (acc_valid && acc_write) begin
      for (int b = 0; b < SPACE_BYTES; b++)
        if (hit[b] && !is_ro(b)) mem[b] <= wbyte[b];
    end
  end

  for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
    logic [LW-1:0] ra;
    assign ra = {1'b0, base} + LW'(i);
    assign rd_next[8*i +: 8] = (LW'(i) < eff_len) ? mem[ra[AW-1:0]] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rd_data <= rd_next;
    end
  end

  for (genvar k = 0; k < NUM_ROUTED; k++) begin : g_word
    assign route_words[k] = {mem[2*k+1], mem[2*k]};
  end
endmodule

// File: rtl/intx_route_lookup.sv
module intx_route_lookup
  import intx_route_pkg::*;
(
  input  route_words_t      route_words,
  input  logic [SLOT_W-1:0] lk_slot,
  input  logic [PIN_W-1:0]  lk_pin,
  output line_t             lk_line
);
  logic [2:0] idx;
  line_t      field_line;

  always_comb begin
    idx        = 3'(lk_slot - SLOT_W'(FIRST_SLOT));
    field_line = route_words[idx][{lk_pin, 2'b00} +: LINE_W];
    if (lk_slot >= SLOT_W'(FIRST_SLOT)) begin
      if (lk_slot == SLOT_W'(FIXED_SLOT)) lk_line = {1'b1, lk_pin};
      else                                lk_line = field_line;
    end else begin
      lk_line = rotate_default(lk_slot, lk_pin);
    end
  end
endmodule

// File: rtl/intx_route_map.sv
module intx_route_map
  import intx_route_pkg::*;
#(
  parameter int SPACE_BYTES = 32,
  parameter int ADDR_IN_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [ADDR_IN_W-1:0] acc_addr,
  input  logic [1:0]           acc_size,
  input  logic [31:0]          acc_wdata,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  input  logic [4:0]           lk_slot,
  input  logic [1:0]           lk_pin,
  output logic [2:0]           lk_line
);
  route_words_t words;

  intx_route_regs #(
    .SPACE_BYTES(SPACE_BYTES), .ADDR_IN_W(ADDR_IN_W), .DATA_BYTES(4)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .route_words(words)
  );

  intx_route_lookup u_lookup (
    .route_words(words), .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_line(lk_line)
  );
endmodule

// File: rtl/intx_route_map_chk.sv
module intx_route_map_chk #(
  parameter int SPACE_BYTES = 32,
  parameter int ADDR_IN_W   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_valid,
  input logic                 acc_write,
  input logic [ADDR_IN_W-1:0] acc_addr,
  input logic [1:0]           acc_size,
  input logic [31:0]          acc_wdata,
  input logic                 rd_valid,
  input logic [31:0]          rd_data,
  input logic [4:0]           lk_slot,
  input logic [1:0]           lk_pin,
  input logic [2:0]           lk_line
);
  localparam int AW = $clog2(SPACE_BYTES);

  // R3
  fixed_slot_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_slot == 5'd30) |-> (lk_line == {1'b1, lk_pin}));

  // R4
  default_upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_slot < 5'd25) |-> (lk_line[2] && lk_line[1:0] == 2'(lk_slot[1:0] + lk_pin)));

  // R8
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);

  // R8
  no_spurious_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc_valid && !acc_write)) |=> !rd_valid);

  // R6
  clamp_zero_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_addr[AW-1:0] == AW'(SPACE_BYTES - 1))
      |=> (rd_data[31:8] == 24'h0));
endmodule

bind intx_route_map intx_route_map_chk #(
  .SPACE_BYTES(SPACE_BYTES), .ADDR_IN_W(ADDR_IN_W)
) u_chk (.*);

// File: tb/intx_route_map_test.sv
module intx_route_map_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [4:0]  lk_slot = '0;
  logic [1:0]  lk_pin = '0;
  logic [2:0]  lk_line;

  intx_route_map uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .lk_slot(lk_slot), .lk_pin(lk_pin),
    .lk_line(lk_line)
  );

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  model [32];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int span(logic [7:0] addr, logic [1:0] size);
    int base = addr % 32;
    int len  = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    if (base + len > 32) len = 32 - base;
    return len;
  endfunction

  // Scoreboard monitor: pop expected read data when a result appears.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R8 unexpected rd_valid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(logic [7:0] addr, logic [1:0] size, logic [31:0] data);
    int base = addr % 32;
    int len = span(addr, size);
    for (int i = 0; i < len; i++)
      if (base + i != 10 && base + i != 11) model[base + i] = data[8*i +: 8];
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = addr; acc_size = size; acc_wdata = data;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] addr, logic [1:0] size, string tag);
    int base = addr % 32;
    int len = span(addr, size);
    logic [31:0] e = '0;
    for (int i = 0; i < len; i++) e[8*i +: 8] = model[base + i];
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = addr; acc_size = size;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic look(int slot, int pin, string tag);
    logic [2:0] e;
    if (slot == 30) e = 3'(4 + pin);
    else if (slot >= 25) begin
      logic [15:0] w = {model[2*(slot-25)+1], model[2*(slot-25)]};
      e = w[4*pin +: 3];
    end else e = 3'(((slot + pin) % 4) + 4);
    lk_slot = 5'(slot); lk_pin = 2'(pin);
    #1;
    check(tag, {29'h0, lk_line}, {29'h0, e});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 32; b++) model[b] = 8'h00;
    for (int s = 0; s < 7; s++)
      if (s != 5) begin model[2*s] = 8'h10; model[2*s+1] = 8'h32; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset contents
    rd(8'd0,  2'd2, "R1 slots25-26 reset");
    rd(8'd10, 2'd2, "R1 slot30/31 reset");
    rd(8'd14, 2'd2, "R1 spare bytes zero");
    // R2 default words drive lookup
    for (int p = 0; p < 4; p++) look(25, p, "R2 reset slot25");
    // R3 fixed slot
    for (int p = 0; p < 4; p++) look(30, p, "R3 slot30 lookup");
    // R4 rotation
    look(3, 2, "R4 slot3 pin2");
    look(0, 0, "R4 slot0 pin0");
    look(24, 3, "R4 slot24 pin3");
    // R8 write visible next cycle, R2 field decode
    wr(8'd2, 2'd1, 32'h0000_7654);
    for (int p = 0; p < 4; p++) look(26, p, "R8 R2 slot26 new word");
    wr(8'd2, 2'd1, 32'h0000_F9A8);
    for (int p = 0; p < 4; p++) look(26, p, "R2 top field bit dropped");
    // R3 writes ignored
    wr(8'd10, 2'd1, 32'h0000_FFFF);
    rd(8'd10, 2'd1, "R3 slot30 reads zero");
    look(30, 1, "R3 slot30 after write");
    // R5 masking
    wr(8'd48, 2'd0, 32'h0000_00AB);
    rd(8'd16, 2'd0, "R5 masked address");
    // R6 clamp without wrap
    wr(8'd30, 2'd2, 32'h4433_2211);
    rd(8'd30, 2'd2, "R6 clamped read");
    rd(8'd0, 2'd0, "R6 byte0 untouched");
    rd(8'd31, 2'd3, "R6 last byte size3");
    // R7 single byte lane and size code 3
    wr(8'd13, 2'd0, 32'h0000_0005);
    look(31, 2, "R7 byte write pin2");
    look(31, 3, "R7 byte write pin3");
    wr(8'd4, 2'd3, 32'hDEAD_BEEF);
    rd(8'd4, 2'd2, "R7 size3 four bytes");
    rd(8'd5, 2'd1, "R7 lane order");
    repeat (3) @(negedge clk);
    check("R8 all reads returned", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule